// File: doc/BRIEF.md
# Reservation Schedule Queue

This block sits on one input port of a router whose control and data traffic travel on separate networks. For each packet, a single narrow control flit arrives ahead of the data. It holds the routing decision for that packet: the output port to use and the output virtual channel. The block stores these decisions in a small first-in first-out schedule. Because the control side may run ahead of the data side, several reservations can be waiting before any data flit shows up.

Data flits carry only a payload and head/tail markers. They carry no destination. Each accepted data flit is forwarded to the crossbar, tagged with the port and virtual channel of the oldest waiting reservation. When a flit marked as tail is accepted, that reservation is retired and the next one takes its place. If no reservation is waiting, the data side is held off, so a flit is never forwarded without a route.

The crossbar-side outputs are registered. An accepted flit appears on them one cycle after acceptance.

Top module: `resq_steer`

## Requirements
- R1: A control flit is accepted on a cycle where ctl_valid and ctl_ready are both high. Its ctl_port and ctl_vc are appended to the back of the schedule.
- R2: ctl_ready is low exactly when the schedule holds DEPTH entries (DEPTH is 4 by default). It is high otherwise.
- R3: dat_ready is low exactly when the schedule is empty. A data flit offered while dat_ready is low is not forwarded: out_valid is low on the following cycle.
- R4: A data flit is accepted when dat_valid and dat_ready are both high. On the next cycle out_valid is high. out_port and out_vc equal the oldest schedule entry. out_payload, out_head and out_tail equal the flit's payload and markers.
- R5: Reservations are consumed in the order their control flits were accepted. The oldest entry is removed on the cycle a flit with dat_tail=1 is accepted. A flit with dat_tail=0 leaves the oldest entry in place for the next flit.
- R6: If a control flit is accepted and a tail flit is accepted in the same cycle, both take effect and the number of stored entries is unchanged.
- R7: out_valid is low on any cycle that follows a cycle with no accepted data flit.
- R8: While rst is high at a clock edge, the schedule is emptied and out_valid is cleared. After reset, ctl_ready is high and dat_ready is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctl_valid | input | 1 | Control flit offered |
| ctl_ready | output | 1 | Schedule can accept a control flit |
| ctl_port | input | PORT_W | Reserved output port |
| ctl_vc | input | VC_W | Reserved output virtual channel |
| dat_valid | input | 1 | Data flit offered |
| dat_ready | output | 1 | A reservation is waiting, so a data flit can be taken |
| dat_head | input | 1 | First flit of a packet |
| dat_tail | input | 1 | Last flit of a packet |
| dat_payload | input | DATA_W | Data flit payload |
| out_valid | output | 1 | Steered flit valid toward the crossbar |
| out_port | output | PORT_W | Crossbar output port select |
| out_vc | output | VC_W | Output virtual channel select |
| out_head | output | 1 | Forwarded head marker |
| out_tail | output | 1 | Forwarded tail marker |
| out_payload | output | DATA_W | Forwarded payload |

## Verification
A corrupted occupancy count shows up at once as a wrong ctl_ready or dat_ready. The bench checks these every cycle against a reference queue, so a miscount is reported on the cycle the ready level differs.

A corrupted pointer or stored entry shows up one cycle after the next accepted flit, as a wrong out_port or out_vc. A pop that is missed or taken early stays hidden until the next packet boundary, and then shows as a whole packet steered with the previous or following reservation.

Stimulus phases that fill the schedule, drain it, and push and pop together place these errors at the full, empty and simultaneous-update boundaries.

// File: rtl/resq_pkg.sv
package resq_pkg;
  localparam int DEF_DEPTH  = 4;
  localparam int DEF_NPORT  = 5;
  localparam int DEF_NVC    = 2;
  localparam int DEF_DATA_W = 32;

  typedef struct packed {
    logic head;
    logic tail;
  } flit_mark_t;
endpackage

// File: rtl/resq_sched_fifo.sv
module resq_sched_fifo #(
  parameter int DEPTH = 4,
  parameter int ENT_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [ENT_W-1:0] wr_data,
  input  logic             rd_en,
  output logic [ENT_W-1:0] rd_data,
  output logic             full,
  output logic             empty
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

  logic [ENT_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0] wr_ptr, rd_ptr;
  logic [CNT_W-1:0] count;

  // storage without reset so it can map to on-chip memory
  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_ptr] <= wr_data;
  end

  assign rd_data = mem[rd_ptr];
  assign full    = (count == CNT_W'(DEPTH));
  assign empty   = (count == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (wr_en) wr_ptr <= (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
      if (rd_en) rd_ptr <= (rd_ptr == LAST) ? '0 : rd_ptr + 1'b1;
      case ({wr_en, rd_en})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  assert_no_overflow_R2: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> (count < CNT_W'(DEPTH)));
  assert_no_underflow_R3: assert property (@(posedge clk) disable iff (rst)
    rd_en |-> (count != '0));
  assert_count_hold_R6: assert property (@(posedge clk) disable iff (rst)
    (wr_en && rd_en) |=> $stable(count));
endmodule

// File: rtl/resq_out_stage.sv
module resq_out_stage #(
  parameter int PORT_W = 3,
  parameter int VC_W   = 1,
  parameter int DATA_W = 32
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                fire,
  input  logic [PORT_W-1:0]   sel_port,
  input  logic [VC_W-1:0]     sel_vc,
  input  resq_pkg::flit_mark_t mark,
  input  logic [DATA_W-1:0]   payload,
  output logic                out_valid,
  output logic [PORT_W-1:0]   out_port,
  output logic [VC_W-1:0]     out_vc,
  output logic                out_head,
  output logic                out_tail,
  output logic [DATA_W-1:0]   out_payload
);
  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid   <= 1'b0;
      out_port    <= '0;
      out_vc      <= '0;
      out_head    <= 1'b0;
      out_tail    <= 1'b0;
      out_payload <= '0;
    end else begin
      out_valid <= fire;
      if (fire) begin
        out_port    <= sel_port;
        out_vc      <= sel_vc;
        out_head    <= mark.head;
        out_tail    <= mark.tail;
        out_payload <= payload;
      end
    end
  end

  assert_fire_shows_R4: assert property (@(posedge clk) disable iff (rst)
    fire |=> out_valid);
  assert_idle_quiet_R7: assert property (@(posedge clk) disable iff (rst)
    !fire |=> !out_valid);
endmodule

// File: rtl/resq_steer.sv
module resq_steer #(
  parameter int DEPTH  = resq_pkg::DEF_DEPTH,
  parameter int NPORT  = resq_pkg::DEF_NPORT,
  parameter int NVC    = resq_pkg::DEF_NVC,
  parameter int DATA_W = resq_pkg::DEF_DATA_W,
  localparam int PORT_W = (NPORT > 1) ? $clog2(NPORT) : 1,
  localparam int VC_W   = (NVC > 1) ? $clog2(NVC) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ctl_valid,
  output logic              ctl_ready,
  input  logic [PORT_W-1:0] ctl_port,
  input  logic [VC_W-1:0]   ctl_vc,
  input  logic              dat_valid,
  output logic              dat_ready,
  input  logic              dat_head,
  input  logic              dat_tail,
  input  logic [DATA_W-1:0] dat_payload,
  output logic              out_valid,
  output logic [PORT_W-1:0] out_port,
  output logic [VC_W-1:0]   out_vc,
  output logic              out_head,
  output logic              out_tail,
  output logic [DATA_W-1:0] out_payload
);
  localparam int ENT_W = PORT_W + VC_W;

  logic             full, empty, push, accept, pop;
  logic [ENT_W-1:0] head_ent;
  resq_pkg::flit_mark_t mark;

  assign ctl_ready = !full;
  assign dat_ready = !empty;
  assign push      = ctl_valid && ctl_ready;
  assign accept    = dat_valid && dat_ready;
  assign pop       = accept && dat_tail;
  assign mark      = '{head: dat_head, tail: dat_tail};

  resq_sched_fifo #(.DEPTH(DEPTH), .ENT_W(ENT_W)) u_sched (
    .clk(clk), .rst(rst),
    .wr_en(push), .wr_data({ctl_port, ctl_vc}),
    .rd_en(pop), .rd_data(head_ent),
    .full(full), .empty(empty)
  );

  resq_out_stage #(.PORT_W(PORT_W), .VC_W(VC_W), .DATA_W(DATA_W)) u_out (
    .clk(clk), .rst(rst), .fire(accept),
    .sel_port(head_ent[ENT_W-1:VC_W]), .sel_vc(head_ent[VC_W-1:0]),
    .mark(mark), .payload(dat_payload),
    .out_valid(out_valid), .out_port(out_port), .out_vc(out_vc),
    .out_head(out_head), .out_tail(out_tail), .out_payload(out_payload)
  );

  assert_no_unrouted_R3: assert property (@(posedge clk) disable iff (rst)
    (dat_valid && !dat_ready) |=> !out_valid);
  assert_reset_state_R8: assert property (@(posedge clk)
    rst |=> (!out_valid && ctl_ready && !dat_ready));
endmodule

// File: tb/resq_steer_test.sv
module resq_steer_test;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH  = 4;
  localparam int NPORT  = 5;
  localparam int NVC    = 2;
  localparam int DATA_W = 32;
  localparam int PORT_W = $clog2(NPORT);
  localparam int VC_W   = $clog2(NVC);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ctl_valid = 1'b0, dat_valid = 1'b0, dat_head = 1'b0, dat_tail = 1'b0;
  logic [PORT_W-1:0] ctl_port = '0;
  logic [VC_W-1:0]   ctl_vc = '0;
  logic [DATA_W-1:0] dat_payload = '0;
  logic ctl_ready, dat_ready, out_valid, out_head, out_tail;
  logic [PORT_W-1:0] out_port;
  logic [VC_W-1:0]   out_vc;
  logic [DATA_W-1:0] out_payload;

  int errors = 0, checks = 0;
  bit done = 0;

  // reference queue
  int q_port [64];
  int q_vc   [64];
  int q_rd = 0, q_wr = 0;
  bit e_v = 0, e_h = 0, e_t = 0;
  int e_port = 0, e_vc = 0;
  logic [DATA_W-1:0] e_pay = '0;
  bit prev_both = 0, prev_stall = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  resq_steer #(.DEPTH(DEPTH), .NPORT(NPORT), .NVC(NVC), .DATA_W(DATA_W)) uut (
    .clk(clk), .rst(rst),
    .ctl_valid(ctl_valid), .ctl_ready(ctl_ready), .ctl_port(ctl_port), .ctl_vc(ctl_vc),
    .dat_valid(dat_valid), .dat_ready(dat_ready), .dat_head(dat_head), .dat_tail(dat_tail),
    .dat_payload(dat_payload),
    .out_valid(out_valid), .out_port(out_port), .out_vc(out_vc),
    .out_head(out_head), .out_tail(out_tail), .out_payload(out_payload)
  );

  function automatic int occ();
    return q_wr - q_rd;
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic check_ports();
    string rq;
    rq = prev_both ? "R6" : ((occ() == DEPTH) ? "R2" : "R1");
    check(ctl_ready == (occ() != DEPTH), rq, "ctl_ready", ctl_ready, occ() != DEPTH);
    check(dat_ready == (occ() != 0), prev_both ? "R6" : "R3", "dat_ready",
          dat_ready, occ() != 0);
    check(out_valid == e_v, prev_stall ? "R3" : (e_v ? "R4" : "R7"), "out_valid",
          out_valid, e_v);
    if (e_v && out_valid) begin
      check(out_port == e_port, "R5", "out_port", out_port, e_port);
      check(out_vc == e_vc, "R5", "out_vc", out_vc, e_vc);
      check({out_head, out_tail} == {e_h, e_t}, "R4", "markers",
            {out_head, out_tail}, {e_h, e_t});
      check(out_payload == e_pay, "R4", "out_payload", out_payload, e_pay);
    end
  endtask

  // one cycle: at negedge check, drive, and update the model
  task automatic cycle(input int pc, input int pd);
    bit push, acc, pop;
    check_ports();
    ctl_valid   = (($urandom % 100) < pc);
    ctl_port    = PORT_W'($urandom % NPORT);
    ctl_vc      = VC_W'($urandom % NVC);
    dat_valid   = (($urandom % 100) < pd);
    dat_tail    = (($urandom % 3) == 0);
    dat_head    = ($urandom % 2);
    dat_payload = $urandom;
    push = ctl_valid && (occ() != DEPTH);
    acc  = dat_valid && (occ() != 0);
    pop  = acc && dat_tail;
    prev_both  = push && pop;
    prev_stall = dat_valid && (occ() == 0);
    e_v = acc;
    if (acc) begin
      e_port = q_port[q_rd % 64];
      e_vc   = q_vc[q_rd % 64];
      e_h = dat_head; e_t = dat_tail; e_pay = dat_payload;
    end
    if (push) begin
      q_port[q_wr % 64] = int'(ctl_port);
      q_vc[q_wr % 64]   = int'(ctl_vc);
      q_wr++;
    end
    if (pop) q_rd++;
    @(negedge clk);
  endtask

  initial begin
    void'($urandom(32'd4031));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R8 reset state
    check(ctl_ready == 1'b1, "R8", "ctl_ready after reset", ctl_ready, 1);
    check(dat_ready == 1'b0, "R8", "dat_ready after reset", dat_ready, 0);
    check(out_valid == 1'b0, "R8", "out_valid after reset", out_valid, 0);
    // directed: data offered with empty schedule (R3)
    for (int i = 0; i < 5; i++) cycle(0, 100);
    // directed: fill to full (R2), then drain
    for (int i = 0; i < 12; i++) cycle(100, 0);
    for (int i = 0; i < 30; i++) cycle(0, 100);
    // random phases: control heavy, data heavy, balanced
    for (int ph = 0; ph < 30; ph++) begin
      int pc, pd;
      pc = (ph % 3 == 0) ? 90 : ((ph % 3 == 1) ? 20 : 60);
      pd = (ph % 3 == 0) ? 30 : ((ph % 3 == 1) ? 90 : 70);
      for (int i = 0; i < 100; i++) cycle(pc, pd);
    end
    ctl_valid = 0; dat_valid = 0;
    @(negedge clk);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule